// File: doc/BRIEF.md
# Byte-Wide Memory-Mapped Digital I/O Port

This block is a small digital I/O port that sits on a byte-addressed register bus. It exposes three byte-wide registers at consecutive offsets. The first holds the synchronised levels of the pins and can only be read. The second holds the value the pins drive. The third sets the direction of each pin. Each pin reaches the pad logic through three separate vectors: the sampled level in, the drive value out, and an output enable.

Software can load a pin's drive value while the pin is still an input. The value waits in the output register and appears on the pad once the direction bit switches that pin to output. Writes are synchronous and reads are combinational.

Word-sized accesses are accepted. A word write stores only its low byte. A word read places the addressed register's byte in both halves of the result, so the upper half repeats the lower one instead of showing a neighbour.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and directly after it is released, the output register and the direction register read 0, `pin_oe` is all 0 (every pin an input) and `pin_out` is all 0.
- R2: The direction register sits at offset 2. A bit value of 1 makes that pin an output and 0 makes it an input. From the clock edge that captures a write, `pin_oe` equals the register contents bit for bit.
- R3: The output register sits at offset 1. A write to it is stored whatever the direction bits hold, and `pin_out` shows the stored value from the capturing edge on. A pin's stored bit reaches the pad once its direction bit turns to 1, with no rewrite needed.
- R4: The input register sits at offset 0. A read of it returns the level `pin_in` held two rising clock edges earlier, because the pins pass through a two-flop synchroniser.
- R5: A write to offset 0 changes nothing. The output register, the direction register, `pin_out` and `pin_oe` keep their values.
- R6: A byte read (`bus_word`=0) of a mapped offset returns the register in `bus_rdata[7:0]` and zero in `bus_rdata[15:8]`.
- R7: A word read (`bus_word`=1) of a mapped offset returns the register byte in both `bus_rdata[7:0]` and `bus_rdata[15:8]`.
- R8: Write data always travels on `bus_wdata[7:0]`. A word write stores only that low byte into the addressed register, ignores `bus_wdata[15:8]`, and leaves the register at the next offset unchanged.
- R9: Any offset above 2 reads as zero for both access sizes, and writes to such an offset change no register and no pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte offset of the access within the block |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_wdata | input | 16 | Write data; only bits [7:0] are used |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pin_in | input | PORT_W (8) | Asynchronous pad levels |
| pin_out | output | PORT_W (8) | Drive value for each pad |
| pin_oe | output | PORT_W (8) | Output enable for each pad, 1 = drive |

## Verification
The bench loads the output register while every pin is an input, then switches the direction bits. A design that drops or gates the early write would leave `pin_out` at zero or need a second write. It samples the input register after one edge and again after two. A design with a missing synchroniser stage shows the new level one cycle early, and one with an extra stage shows it a cycle late. Word accesses are checked in both directions. A wrong word read would put zero or the next register in the upper half. A wrong word write would store the high byte or spill into the neighbouring register. Writes to the read-only offset and to unmapped offsets are followed by readback of both writable registers and the pins, to catch a decoder that aliases them onto a real register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // Register selector produced by the address decoder
   typedef enum logic [1:0] {
      SEL_IN   = 2'd0,
      SEL_OUT  = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_NONE = 2'd3
   } gpio_sel_e;

   localparam int unsigned OFS_IN  = 0;
   localparam int unsigned OFS_OUT = 1;
   localparam int unsigned OFS_DIR = 2;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned BUS_W   = 2 * BYTE_W;

   function automatic gpio_sel_e gpio_decode(input int unsigned ofs);
      gpio_sel_e s;
      case (ofs)
         OFS_IN:  s = SEL_IN;
         OFS_OUT: s = SEL_OUT;
         OFS_DIR: s = SEL_DIR;
         default: s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= '0;
         else        stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  gpio_sel_e         sel,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] out_q,
   output logic [PORT_W-1:0] dir_q
);
   logic out_we;
   logic dir_we;

   assign out_we = wr && (sel == SEL_OUT);
   assign dir_we = wr && (sel == SEL_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (out_we) out_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= wdata;
   end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
   import gpio_pkg::*;
#(
   parameter int unsigned PORT_W = 8
) (
   input  gpio_sel_e         sel,
   input  logic              word,
   input  logic [PORT_W-1:0] in_q,
   input  logic [PORT_W-1:0] out_q,
   input  logic [PORT_W-1:0] dir_q,
   output logic [BUS_W-1:0]  rdata
);
   logic [PORT_W-1:0] pick;
   logic [BYTE_W-1:0] lane;

   always_comb begin
      case (sel)
         SEL_IN:  pick = in_q;
         SEL_OUT: pick = out_q;
         SEL_DIR: pick = dir_q;
         default: pick = '0;
      endcase
   end

   if (PORT_W < BYTE_W) begin : g_pad
      assign lane = {{(BYTE_W-PORT_W){1'b0}}, pick};
   end else begin : g_full
      assign lane = pick;
   end

   // Upper half repeats the addressed byte on word reads
   assign rdata = word ? {lane, lane} : {{BYTE_W{1'b0}}, lane};
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_word,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);
   if (PORT_W < 1 || PORT_W > BYTE_W) begin : g_bad_width
      $error("PORT_W must lie in 1..8");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   gpio_sel_e         sel;
   logic [PORT_W-1:0] in_q;
   logic [PORT_W-1:0] out_q;
   logic [PORT_W-1:0] dir_q;
   logic              unused_wd;

   assign sel       = gpio_decode(int'(bus_addr));
   assign unused_wd = ^bus_wdata[15:PORT_W];

   gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_q)
   );

   gpio_regs #(.PORT_W(PORT_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .sel   (sel),
      .wdata (bus_wdata[PORT_W-1:0]),
      .out_q (out_q),
      .dir_q (dir_q)
   );

   gpio_rdmux #(.PORT_W(PORT_W)) u_rdmux (
      .sel   (sel),
      .word  (bus_word),
      .in_q  (in_q),
      .out_q (out_q),
      .dir_q (dir_q),
      .rdata (bus_rdata)
   );

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned PORT_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_word,
   input logic [15:0]       bus_wdata,
   input logic [15:0]       bus_rdata,
   input logic [PORT_W-1:0] pin_out,
   input logic [PORT_W-1:0] pin_oe
);
   // R2
   dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(2)) |=> pin_oe == $past(bus_wdata[PORT_W-1:0]));

   // R3
   out_to_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(1)) |=> pin_out == $past(bus_wdata[PORT_W-1:0]));

   // R5
   in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(0)) |=> ($stable(pin_out) && $stable(pin_oe)));

   // R6
   byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_word |-> bus_rdata[15:8] == 8'h00);

   // R7
   word_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_word |-> bus_rdata[15:8] == bus_rdata[7:0]);

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(2)) |-> bus_rdata == 16'h0000);

   // R9
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr > ADDR_W'(2)) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_port gpio_port_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_word  (bus_word),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_word = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_word  (bus_word),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic w);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_word = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic w, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_word = w;
      #1 d = bus_rdata;
      bus_word = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 pin_oe", {8'h0, pin_oe}, 16'h0);
      chk("R1 pin_out", {8'h0, pin_out}, 16'h0);
      rd(4'd1, 1'b0, d); chk("R1 out reg", d, 16'h0);
      rd(4'd2, 1'b0, d); chk("R1 dir reg", d, 16'h0);
   endtask

   task automatic t_out_then_dir();
      logic [15:0] d;
      wr(4'd1, 16'h00A5, 1'b0);
      chk("R3 pin_out while input", {8'h0, pin_out}, 16'h00A5);
      chk("R3 oe still off", {8'h0, pin_oe}, 16'h0);
      wr(4'd2, 16'h000F, 1'b0);
      chk("R2 pin_oe", {8'h0, pin_oe}, 16'h000F);
      chk("R3 held value driven", {8'h0, pin_out & pin_oe}, 16'h0005);
      rd(4'd2, 1'b0, d); chk("R6 byte read dir", d, 16'h000F);
      rd(4'd1, 1'b0, d); chk("R6 byte read out", d, 16'h00A5);
   endtask

   task automatic t_input_sync();
      logic [15:0] d;
      @(negedge clk); pin_in = 8'h3C;
      // one edge later the first stage has it, the readable stage not yet
      rd(4'd0, 1'b0, d); chk("R4 after one edge", d, 16'h0000);
      rd(4'd0, 1'b0, d); chk("R4 after two edges", d, 16'h003C);
   endtask

   task automatic t_in_write();
      logic [15:0] d;
      wr(4'd0, 16'h00FF, 1'b0);
      chk("R5 pin_out kept", {8'h0, pin_out}, 16'h00A5);
      chk("R5 pin_oe kept", {8'h0, pin_oe}, 16'h000F);
      rd(4'd0, 1'b0, d); chk("R5 in reg kept", d, 16'h003C);
      rd(4'd1, 1'b0, d); chk("R5 out reg kept", d, 16'h00A5);
      rd(4'd2, 1'b0, d); chk("R5 dir reg kept", d, 16'h000F);
   endtask

   task automatic t_word();
      logic [15:0] d;
      rd(4'd1, 1'b1, d); chk("R7 word read out", d, 16'hA5A5);
      rd(4'd0, 1'b1, d); chk("R7 word read in", d, 16'h3C3C);
      wr(4'd2, 16'h5A81, 1'b1);
      rd(4'd2, 1'b0, d); chk("R8 word write low byte", d, 16'h0081);
      chk("R8 pin_oe", {8'h0, pin_oe}, 16'h0081);
      rd(4'd1, 1'b0, d); chk("R8 neighbour untouched", d, 16'h00A5);
      wr(4'd1, 16'hFF3E, 1'b1);
      rd(4'd1, 1'b0, d); chk("R8 out word write", d, 16'h003E);
      rd(4'd2, 1'b0, d); chk("R8 dir untouched", d, 16'h0081);
   endtask

   task automatic t_unmapped();
      logic [15:0] d;
      wr(4'd3, 16'h00FF, 1'b0);
      wr(4'd15, 16'hFFFF, 1'b1);
      rd(4'd3, 1'b0, d); chk("R9 byte read 3", d, 16'h0);
      rd(4'd15, 1'b1, d); chk("R9 word read 15", d, 16'h0);
      rd(4'd1, 1'b0, d); chk("R9 out kept", d, 16'h003E);
      rd(4'd2, 1'b0, d); chk("R9 dir kept", d, 16'h0081);
      chk("R9 pins kept", {pin_oe, pin_out}, 16'h813E);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      chk("R1 oe in reset", {8'h0, pin_oe}, 16'h0);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_out_then_dir();
      t_input_sync();
      t_in_write();
      t_word();
      t_unmapped();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule